// File: doc/BRIEF.md
# UART Modem Control and Diagnostic Loopback Unit

This block is the modem-handshake and self-test corner of a 16550-class UART. It holds a small control register that drives the four active-low modem outputs. It synchronises the four active-low modem inputs into a status register that also records which lines have changed. It sits between the UART's shift registers and the device pins, so it also decides where the serial bits go.

When the loop bit of the control register is set, the serial bit leaving the transmitter is fed straight back into the receiver. The control outputs are wrapped onto the status inputs. The pins are isolated: the transmit pin idles at mark, the modem outputs read inactive, and the external modem inputs and receive pin are ignored. The CTS-derived flow-control signal keeps working on the wrapped value, so automatic flow control can be exercised with no external wiring.

The register port and the bit-serial paths are plain signals with no valid/ready handshake. A register access completes in the cycle it is presented. The serial bits are level signals sampled by the shift registers, so there is nothing to back-pressure.

Top module: `uart_modem_loop`

## Requirements
- R1: After reset the control register reads 0, all four modem outputs are high (inactive), loopback is off, and the status change bits (status bits 3:0) read 0.
- R2: A write with `reg_addr`=0 loads the control register from `wr_data`: bit 0 DTR, bit 1 RTS, bit 2 OUT1, bit 3 OUT2, bit 4 loop. A read with `reg_addr`=0 returns those five bits, with bits 7:5 reading 0. A write with `reg_addr`=1 changes nothing.
- R3: With loop clear, `dtr_n`, `rts_n`, `out1_n` and `out2_n` are the inverses of control bits 0, 1, 2 and 3. `tx_pin` equals `tx_bit`, and `rx_bit` equals `rx_pin`.
- R4: With loop set, `tx_pin`, `rts_n`, `dtr_n`, `out1_n` and `out2_n` are all 1, whatever the control bits and `tx_bit` are.
- R5: With loop set, `rx_bit` equals `tx_bit` and `rx_pin` has no effect.
- R6: With loop clear, status bits 4, 5, 6 and 7 show CTS, DSR, RI and CD as active-high (the inverse of `cts_n`, `dsr_n`, `ri_n`, `dcd_n`). They take effect on the third rising clock edge after a pin changes: two synchroniser stages, then the status stage.
- R7: With loop set, status bits 4, 5, 6 and 7 follow control bits RTS, DTR, OUT1 and OUT2 respectively, one edge after the control register changes. The four external modem inputs have no effect.
- R8: Status bits 0, 1 and 3 set when CTS, DSR and CD change in either direction. Status bit 2 sets when RI goes from active to inactive. All four change bits stay set until cleared.
- R9: A read with `reg_addr`=1 returns the status and clears the change bits at the next edge. A change detected at that same edge is recorded, not lost.
- R10: `flow_cts` equals status bit 4 in both modes, so flow control sees RTS wrapped back while loop is set.
- R11: Leaving loopback with `rx_pin` high gives `rx_bit`=1 from the first cycle after the write edge, so the receiver sees no break.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Write data for the control register |
| rd_en | input | 1 | Register read strobe (a status read clears change bits) |
| rd_data | output | 8 | Read data for the addressed register |
| tx_bit | input | 1 | Serial bit from the transmit shift register |
| rx_bit | output | 1 | Serial bit to the receive shift register |
| tx_pin | output | 1 | Serial transmit pin |
| rx_pin | input | 1 | Serial receive pin |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| out1_n | output | 1 | General output 1, active low |
| out2_n | output | 1 | General output 2, active low |
| cts_n | input | 1 | Clear-to-send pin, active low |
| dsr_n | input | 1 | Data-set-ready pin, active low |
| ri_n | input | 1 | Ring-indicator pin, active low |
| dcd_n | input | 1 | Carrier-detect pin, active low |
| flow_cts | output | 1 | Active-high CTS for the flow-control logic |

## Verification
The bench sweeps all sixteen modem-input patterns and all thirty-two control values. A design that takes its status from the pins while loop is set, or misses the inversion, fails the status compare. A design that drives the idle level badly shows stray handshake levels on the pins. The RI change bit is checked separately from the others, so a design that flags RI on the leading edge, or on both edges, is caught.

A directed race makes a pin change land on the same edge as a status read. A design that lets the clear win loses that change. A last case leaves loopback with the receive pin high and the transmitter sending zero. A design that keeps the wrapped path for one more cycle, or passes the stale value, shows a break-like low on `rx_bit`.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;
  // control register layout, bit 0 upward: dtr, rts, op1, op2, loop
  typedef struct packed {
    logic loop;
    logic op2;
    logic op1;
    logic rts;
    logic dtr;
  } mctrl_t;

  localparam int CTRL_W = 5;
  localparam int LINES  = 4;
  localparam int REG_W  = 8;

  // line order inside a status nibble
  localparam int L_CTS = 0;
  localparam int L_DSR = 1;
  localparam int L_RI  = 2;
  localparam int L_CD  = 3;

  // lines whose change bit is set on either edge (RI uses the trailing edge only)
  localparam logic [LINES-1:0] BOTH_EDGE = 4'b1011;
  localparam logic [LINES-1:0] FALL_EDGE = 4'b0100;
endpackage

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg
  import uart_modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CTRL_W-1:0] din,
  output mctrl_t            ctrl
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl <= '0;
    else if (load) ctrl <= mctrl_t'(din);
  end
endmodule

// File: rtl/modem_sync.sv
module modem_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage[0] <= '0;
    else stage[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else stage[s] <= stage[s-1];
    end
  end

  assign q = stage[STAGES-1];
endmodule

// File: rtl/modem_status.sv
module modem_status
  import uart_modem_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] src,
  input  logic             clr,
  output logic [LINES-1:0] cur,
  output logic [LINES-1:0] dlt
);
  logic [LINES-1:0] chg;

  always_comb chg = ((src ^ cur) & BOTH_EDGE) | (cur & ~src & FALL_EDGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur <= '0;
      dlt <= '0;
    end else begin
      cur <= src;
      dlt <= (clr ? '0 : dlt) | chg;   // a change on the clearing edge survives
    end
  end
endmodule

// File: rtl/loop_steer.sv
module loop_steer
  import uart_modem_pkg::*;
(
  input  mctrl_t ctrl,
  input  logic   tx_bit,
  input  logic   rx_pin,
  output logic   tx_pin,
  output logic   rx_bit,
  output logic   rts_n,
  output logic   dtr_n,
  output logic   out1_n,
  output logic   out2_n
);
  always_comb begin
    if (ctrl.loop) begin
      tx_pin = 1'b1;
      rx_bit = tx_bit;
      rts_n  = 1'b1;
      dtr_n  = 1'b1;
      out1_n = 1'b1;
      out2_n = 1'b1;
    end else begin
      tx_pin = tx_bit;
      rx_bit = rx_pin;
      rts_n  = ~ctrl.rts;
      dtr_n  = ~ctrl.dtr;
      out1_n = ~ctrl.op1;
      out2_n = ~ctrl.op2;
    end
  end
endmodule

// File: rtl/uart_modem_loop.sv
module uart_modem_loop
  import uart_modem_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [REG_W-1:0]  rd_data,
  input  logic              tx_bit,
  output logic              rx_bit,
  output logic              tx_pin,
  input  logic              rx_pin,
  output logic              rts_n,
  output logic              dtr_n,
  output logic              out1_n,
  output logic              out2_n,
  input  logic              cts_n,
  input  logic              dsr_n,
  input  logic              ri_n,
  input  logic              dcd_n,
  output logic              flow_cts
);
  localparam int PAD_W = REG_W - CTRL_W;

  mctrl_t           ctrl_q;
  logic [LINES-1:0] pin_act, pin_sync, wrap, src, cur, dlt;
  logic             loop_on, msr_clr;

  modem_ctrl_reg i_ctrl (
    .clk(clk), .rst_n(rst_n), .load(wr_en & ~reg_addr), .din(wr_data), .ctrl(ctrl_q)
  );

  always_comb begin
    pin_act[L_CTS] = ~cts_n;
    pin_act[L_DSR] = ~dsr_n;
    pin_act[L_RI]  = ~ri_n;
    pin_act[L_CD]  = ~dcd_n;
    wrap[L_CTS]    = ctrl_q.rts;
    wrap[L_DSR]    = ctrl_q.dtr;
    wrap[L_RI]     = ctrl_q.op1;
    wrap[L_CD]     = ctrl_q.op2;
  end

  modem_sync #(.W(LINES), .STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_act), .q(pin_sync)
  );

  assign loop_on = ctrl_q.loop;
  assign src     = loop_on ? wrap : pin_sync;
  assign msr_clr = rd_en & reg_addr;

  modem_status i_stat (
    .clk(clk), .rst_n(rst_n), .src(src), .clr(msr_clr), .cur(cur), .dlt(dlt)
  );

  loop_steer i_steer (
    .ctrl(ctrl_q), .tx_bit(tx_bit), .rx_pin(rx_pin), .tx_pin(tx_pin), .rx_bit(rx_bit),
    .rts_n(rts_n), .dtr_n(dtr_n), .out1_n(out1_n), .out2_n(out2_n)
  );

  assign rd_data  = reg_addr ? {cur, dlt} : {{PAD_W{1'b0}}, ctrl_q};
  assign flow_cts = cur[L_CTS];
endmodule

// File: rtl/modem_loop_checker.sv
module modem_loop_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       loop_on,
  input logic       ctrl_rts,
  input logic       tx_bit,
  input logic       rx_bit,
  input logic       tx_pin,
  input logic [3:0] pins_n,
  input logic [3:0] cur,
  input logic [3:0] dlt,
  input logic       clr
);
  p_pins_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |-> (tx_pin && pins_n == 4'hF));

  p_rx_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on |-> (rx_bit == tx_bit));

  p_wrap_cts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_on && $past(loop_on)) |-> (cur[0] == $past(ctrl_rts)));

  p_delta_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((dlt & $past(dlt)) == $past(dlt)));

  p_teri_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlt[2]) |-> ($past(cur[2]) && !cur[2]));
endmodule

bind uart_modem_loop modem_loop_checker i_chk (
  .clk(clk), .rst_n(rst_n), .loop_on(loop_on), .ctrl_rts(ctrl_q.rts),
  .tx_bit(tx_bit), .rx_bit(rx_bit), .tx_pin(tx_pin),
  .pins_n({out2_n, out1_n, dtr_n, rts_n}), .cur(cur), .dlt(dlt), .clr(msr_clr)
);

// File: tb/test_uart_modem_loop.sv
module test_uart_modem_loop;
  logic clk = 0, rst_n = 0;
  logic reg_addr = 0, wr_en = 0, rd_en = 0;
  logic [4:0] wr_data = '0;
  logic [7:0] rd_data;
  logic tx_bit = 1, rx_bit, tx_pin, rx_pin = 1;
  logic rts_n, dtr_n, out1_n, out2_n, flow_cts;
  logic [3:0] ext_n = 4'hF;   // {dcd_n, ri_n, dsr_n, cts_n}

  int n_chk = 0, n_bad = 0;
  logic [4:0] ctrl_m = '0;
  logic [3:0] cur_m = '0, dlt_m = '0;

  always #5 clk = ~clk;

  uart_modem_loop i_uart_modem_loop (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .tx_bit(tx_bit), .rx_bit(rx_bit), .tx_pin(tx_pin),
    .rx_pin(rx_pin), .rts_n(rts_n), .dtr_n(dtr_n), .out1_n(out1_n), .out2_n(out2_n),
    .cts_n(ext_n[0]), .dsr_n(ext_n[1]), .ri_n(ext_n[2]), .dcd_n(ext_n[3]), .flow_cts(flow_cts)
  );

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  function automatic logic [3:0] src_m();
    if (ctrl_m[4]) return {ctrl_m[3], ctrl_m[2], ctrl_m[0], ctrl_m[1]};
    return ~ext_n;
  endfunction

  task automatic settle();
    logic [3:0] nv;
    repeat (5) @(negedge clk);
    nv = src_m();
    dlt_m = dlt_m | ((nv ^ cur_m) & 4'b1011) | (cur_m & ~nv & 4'b0100);
    cur_m = nv;
  endtask

  task automatic wr(logic a, logic [4:0] v);
    @(negedge clk);
    reg_addr = a; wr_data = v; wr_en = 1;
    @(negedge clk);
    wr_en = 0; reg_addr = 0;
    if (!a) ctrl_m = v;
  endtask

  task automatic rd_status(string req);
    @(negedge clk);
    reg_addr = 1; rd_en = 1;
    #1 chk(req, rd_data, {cur_m, dlt_m});
    chk("R10 flow_cts", {7'b0, flow_cts}, {7'b0, cur_m[0]});
    @(negedge clk);
    rd_en = 0; reg_addr = 0;
    dlt_m = '0;
  endtask

  task automatic chk_pins(string req);
    logic [3:0] exp;
    exp = ctrl_m[4] ? 4'hF : ~ctrl_m[3:0];
    #1 chk(req, {4'b0, out2_n, out1_n, rts_n, dtr_n}, {4'b0, exp});
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    reg_addr = 0;
    #1 chk("R1 control", rd_data, 8'h00);
    chk_pins("R1 pins");
    reg_addr = 1;
    #1 chk("R1 deltas", {4'b0, rd_data[3:0]}, 8'h00);
    reg_addr = 0;
    settle();
    rd_status("R1 status");

    // R6 R8: sweep every pin pattern in normal mode
    for (int i = 0; i < 16; i++) begin
      ext_n = 4'(i);
      settle();
      rd_status("R6 R8 status");
    end
    for (int i = 15; i >= 0; i -= 3) begin
      ext_n = 4'(i);
      settle();
      settle();
      rd_status("R8 RI trailing edge");
    end

    // R2 R3 R4 R7: every control value, pins varied while looping
    for (int v = 0; v < 32; v++) begin
      if (v > 16) ext_n = 4'(v) ^ 4'h5;
      @(negedge clk);
      reg_addr = 0; wr_data = 5'(v); wr_en = 1;
      @(negedge clk);
      wr_en = 0;
      ctrl_m = 5'(v);
      #1 chk("R2 readback", rd_data, {3'b0, 5'(v)});
      chk_pins(v[4] ? "R4 isolated pins" : "R3 driven pins");
      settle();
      rd_status(v[4] ? "R7 wrapped status" : "R6 status");
    end

    // R2: write to status address changes nothing
    wr(1, 5'h00);
    reg_addr = 0;
    #1 chk("R2 status write ignored", rd_data, {3'b0, ctrl_m});

    // R3 R5 serial steering
    for (int m = 0; m < 2; m++) begin
      wr(0, m[0] ? 5'h10 : 5'h00);
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        tx_bit = k[0]; rx_pin = k[1];
        #1;
        chk(m[0] ? "R4 tx_pin mark" : "R3 tx_pin", {7'b0, tx_pin}, {7'b0, m[0] ? 1'b1 : k[0]});
        chk(m[0] ? "R5 rx wrap" : "R3 rx pass", {7'b0, rx_bit}, {7'b0, m[0] ? k[0] : k[1]});
      end
    end
    settle();
    rd_status("R7 status after steering");

    // R11 exit loopback with rx high, transmitter sending zero
    @(negedge clk);
    rx_pin = 1; tx_bit = 0;
    #1 chk("R5 loop rx follows tx", {7'b0, rx_bit}, 8'h00);
    @(negedge clk);
    reg_addr = 0; wr_data = 5'h00; wr_en = 1;
    @(posedge clk);
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      wr_en = 0;
      #1 chk("R11 no false break", {7'b0, rx_bit}, 8'h01);
    end
    ctrl_m = '0;
    tx_bit = 1;
    settle();
    rd_status("R6 after exit");

    // R9 pin change lands on the clearing edge
    ext_n = 4'hF;
    settle();
    rd_status("R9 prep");
    @(negedge clk);
    ext_n[0] = 1'b0;          // CTS becomes active
    @(negedge clk);
    @(negedge clk);
    reg_addr = 1; rd_en = 1;  // next edge both clears and records the change
    #1 chk("R9 read before change", rd_data, {cur_m, 4'b0});
    @(negedge clk);
    rd_en = 0; reg_addr = 0;
    cur_m[0] = 1'b1; dlt_m = 4'b0001;
    rd_status("R9 change kept");
    settle();
    rd_status("R9 cleared");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule